// File: doc/BRIEF.md
# Cell-Bus Transmit Ingress Buffer

This block is the physical-layer end of the transmit direction on an 8-bit UTOPIA cell bus. The ATM-layer device pushes cells into it one byte per clock. The byte enable qualifies each byte, and a start-of-cell marker flags the first byte of every cell. The block frames the bytes into fixed-length cells and keeps only complete cells in a slot-organised buffer. It tells the sender, through a cell-room output, whether a whole further cell would fit.

Every enabled byte arrives with an odd-parity bit, and the block checks it. A mismatch raises a sticky error flag, but only while checking is switched on. The flag clears on a pulse. A parity error is only reported: the cell is still stored unchanged. The downstream logic unloads stored cells byte by byte through a simple read port. The port marks the first and last byte of each cell.

Top module: `utx_cell_rx`

## Requirements
- R1: `cell_room` is 1 when fewer than `CELL_SLOTS` (default 2) complete cells are stored, and 0 when the buffer is full. It falls in the cycle after the commit that fills the last slot, and it rises in the cycle after the last byte of a stored cell is read.
- R2: A cell is `CELL_BYTES` (default 53) consecutive enabled bytes. The first of them has `tx_soc` high. Clocks with `tx_en` low carry nothing. A committed cell reads back with every byte in order and unchanged.
- R3: Enabled bytes that arrive outside a cell, before any start-of-cell, are not stored.
- R4: A start-of-cell that arrives while a cell is partly received throws the partial bytes away. The byte count restarts from that byte.
- R5: The parity bit makes the number of ones across `tx_data` and `tx_par` odd. An enabled byte that breaks this sets `par_err` in the next cycle, but only if `par_chk_en` is 1. Every enabled byte is checked, including bytes that are ignored.
- R6: A parity error never drops or changes the cell that carries it.
- R7: `par_err` stays set until a `par_err_clr` pulse. A new error in the same cycle as the clear pulse leaves the flag set.
- R8: A cell whose start-of-cell arrives while `cell_room` is 0 is discarded in full and is never read out.
- R9: `rd_avail` is 1 exactly while at least one complete cell is stored. `rd_data` shows the current byte. `rd_sop` marks byte 0 of a cell and `rd_eop` marks its last byte. `rd_en` takes one byte per clock, and it is ignored while `rd_avail` is 0.
- R10: After a synchronous active-low reset, `cell_room` is 1 and both `rd_avail` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running transmit-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 8 | Cell byte from the ATM-layer device |
| tx_par | input | 1 | Odd-parity bit for `tx_data` |
| tx_en | input | 1 | Byte on `tx_data` is valid this clock |
| tx_soc | input | 1 | Byte on `tx_data` is the first of a cell |
| tx_cell_room | output | 1 | Buffer can take at least one more whole cell |
| par_chk_en | input | 1 | Allows parity errors to set the status flag |
| par_err_clr | input | 1 | One-clock pulse that clears the status flag |
| par_err | output | 1 | Sticky parity error status |
| rd_en | input | 1 | Consume the byte on `rd_data` |
| rd_avail | output | 1 | At least one complete cell is stored |
| rd_data | output | 8 | Current byte of the oldest stored cell |
| rd_sop | output | 1 | `rd_data` is byte 0 of a cell |
| rd_eop | output | 1 | `rd_data` is the last byte of a cell |

## Verification
Three situations are hard to reach from the ports.

- **Cell dropped because the buffer is full.** The bench loads two complete cells without reading, which fills every slot. It then pushes a third cell while `tx_cell_room` is 0. It drains the buffer and confirms that only the first two cells come out.
- **Restart on an early start-of-cell.** The bench stops a cell partway and begins a new one. The read-back must show only the new cell.
- **Parity error arriving with a clear.** A cell carries a byte with bad parity, and the flag-clear pulse lands in that same clock. The bench checks that the flag stays set and that the cell's bytes come back intact.

// File: rtl/utx_pkg.sv
// Package: shared byte type and defaults for the transmit ingress buffer.
// Assumes: cells are a fixed number of bytes and at least two slots exist.
package utx_pkg;
    typedef logic [7:0] cbyte_t;
    localparam int DEF_CELL_BYTES = 53;
    localparam int DEF_CELL_SLOTS = 2;
endpackage

// File: rtl/utx_parity_mon.sv
// Module: utx_parity_mon
// Checks odd parity on every enabled byte and holds a sticky, maskable
// error flag. Assumes the clear input is a pulse. A set in the same cycle as a clear wins.
module utx_parity_mon
    import utx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   byte_vld,
    input  cbyte_t byte_in,
    input  logic   par_in,
    input  logic   chk_en,
    input  logic   clr,
    output logic   err_flag
);
    logic odd_ok;
    logic err_evt;

    // Purpose: decide whether this byte breaks odd parity while checking is on.
    always_comb begin
        odd_ok  = ^{byte_in, par_in};
        err_evt = byte_vld && chk_en && !odd_ok;
    end

    // Purpose: sticky flag, a new error has priority over the clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (err_evt) begin
            err_flag <= 1'b1;
        end else if (clr) begin
            err_flag <= 1'b0;
        end
    end

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag);
    p_flag_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && !(byte_vld && chk_en)) |=> !err_flag);
    p_flag_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && chk_en && (^{byte_in, par_in} == 1'b0)) |=> err_flag);
endmodule

// File: rtl/utx_framer.sv
// Module: utx_framer
// Aligns incoming bytes into cells using the start-of-cell marker. It tells
// the store where each byte goes and when a cell is complete. Assumes the
// room input already describes whole free slots.
module utx_framer
    import utx_pkg::*;
#(
    parameter int CELL_BYTES = DEF_CELL_BYTES,
    localparam int IW = $clog2(CELL_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          soc,
    input  cbyte_t        data,
    input  logic          room,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output cbyte_t        wr_data,
    output logic          commit
);
    localparam logic [IW-1:0] LAST = IW'(CELL_BYTES - 1);

    logic          in_cell;
    logic [IW-1:0] idx;
    logic          start_any;
    logic          start_ok;
    logic          mid_byte;

    // Purpose: classify the current byte and form the write request.
    always_comb begin
        start_any = en && soc;
        start_ok  = start_any && room;
        mid_byte  = en && !soc && in_cell;
        wr_en     = start_ok || mid_byte;
        wr_idx    = start_ok ? '0 : idx;
        wr_data   = data;
        commit    = mid_byte && (idx == LAST);
    end

    // Purpose: track whether a cell is open and the position of the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cell <= 1'b0;
            idx     <= '0;
        end else if (start_any) begin
            in_cell <= room;
            idx     <= room ? IW'(1) : '0;
        end else if (mid_byte) begin
            if (idx == LAST) begin
                in_cell <= 1'b0;
                idx     <= '0;
            end else begin
                idx <= idx + IW'(1);
            end
        end
    end

    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST);
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && soc && room) |=> (in_cell && idx == IW'(1)));
    p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && soc && !room) |=> !in_cell);
    p_no_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_cell && !(en && soc)) |=> !in_cell);
endmodule

// File: rtl/utx_cell_store.sv
// Module: utx_cell_store
// Holds CELL_SLOTS cells of CELL_BYTES bytes, one slot per cell. It counts
// committed cells and serves them byte by byte. Assumes the framer commits
// only into a slot that was free when its cell started.
module utx_cell_store
    import utx_pkg::*;
#(
    parameter int CELL_BYTES = DEF_CELL_BYTES,
    parameter int CELL_SLOTS = DEF_CELL_SLOTS,
    localparam int IW = $clog2(CELL_BYTES),
    localparam int SW = (CELL_SLOTS > 1) ? $clog2(CELL_SLOTS) : 1,
    localparam int CW = $clog2(CELL_SLOTS + 1),
    localparam int NB = CELL_BYTES * CELL_SLOTS,
    localparam int AW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  cbyte_t        wr_data,
    input  logic          commit,
    input  logic          rd_en,
    output logic          room,
    output logic          rd_avail,
    output cbyte_t        rd_data,
    output logic          rd_sop,
    output logic          rd_eop
);
    localparam logic [IW-1:0] LAST  = IW'(CELL_BYTES - 1);
    localparam logic [SW-1:0] SLAST = SW'(CELL_SLOTS - 1);

    cbyte_t        mem [NB];
    logic [SW-1:0] wr_slot;
    logic [SW-1:0] rd_slot;
    logic [IW-1:0] rd_idx;
    logic [CW-1:0] cnt;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          rd_fire;
    logic          rd_done;

    // Purpose: map slot and byte position to a flat address; form flags.
    always_comb begin
        wr_addr  = AW'(wr_slot) * AW'(CELL_BYTES) + AW'(wr_idx);
        rd_addr  = AW'(rd_slot) * AW'(CELL_BYTES) + AW'(rd_idx);
        room     = cnt < CW'(CELL_SLOTS);
        rd_avail = cnt != '0;
        rd_fire  = rd_en && rd_avail;
        rd_done  = rd_fire && (rd_idx == LAST);
        rd_data  = mem[rd_addr];
        rd_sop   = rd_avail && (rd_idx == '0);
        rd_eop   = rd_avail && (rd_idx == LAST);
    end

    // Purpose: byte storage, written at the framer's position in the open slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Purpose: advance the write slot on commit and keep the stored-cell count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot <= '0;
            cnt     <= '0;
        end else begin
            if (commit) begin
                wr_slot <= (wr_slot == SLAST) ? '0 : wr_slot + SW'(1);
            end
            if (commit && !rd_done) begin
                cnt <= cnt + CW'(1);
            end else if (!commit && rd_done) begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    // Purpose: walk the read position through the oldest stored cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot <= '0;
            rd_idx  <= '0;
        end else if (rd_fire) begin
            if (rd_idx == LAST) begin
                rd_idx  <= '0;
                rd_slot <= (rd_slot == SLAST) ? '0 : rd_slot + SW'(1);
            end else begin
                rd_idx <= rd_idx + IW'(1);
            end
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(CELL_SLOTS));
    p_commit_has_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> room);
    p_room_falls_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rd_done && cnt == CW'(CELL_SLOTS - 1)) |=> !room);
    p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_avail) |=> ($stable(rd_idx) && $stable(rd_slot)));
endmodule

// File: rtl/utx_cell_rx.sv
// Module: utx_cell_rx (top)
// Transmit-side cell ingress for an 8-bit cell bus: framing, whole-cell
// buffering, room indication and parity status. Assumes a single clock
// domain for the bus side and the read side.
module utx_cell_rx
    import utx_pkg::*;
#(
    parameter int CELL_BYTES = DEF_CELL_BYTES,
    parameter int CELL_SLOTS = DEF_CELL_SLOTS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_par,
    input  logic       tx_en,
    input  logic       tx_soc,
    output logic       tx_cell_room,
    input  logic       par_chk_en,
    input  logic       par_err_clr,
    output logic       par_err,
    input  logic       rd_en,
    output logic       rd_avail,
    output logic [7:0] rd_data,
    output logic       rd_sop,
    output logic       rd_eop
);
    localparam int IW = $clog2(CELL_BYTES);

    logic          fr_wr_en;
    logic [IW-1:0] fr_wr_idx;
    cbyte_t        fr_wr_data;
    logic          fr_commit;
    logic          st_room;

    utx_parity_mon u_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (tx_en),
        .byte_in  (tx_data),
        .par_in   (tx_par),
        .chk_en   (par_chk_en),
        .clr      (par_err_clr),
        .err_flag (par_err)
    );

    utx_framer #(.CELL_BYTES(CELL_BYTES)) u_frm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tx_en),
        .soc     (tx_soc),
        .data    (tx_data),
        .room    (st_room),
        .wr_en   (fr_wr_en),
        .wr_idx  (fr_wr_idx),
        .wr_data (fr_wr_data),
        .commit  (fr_commit)
    );

    utx_cell_store #(.CELL_BYTES(CELL_BYTES), .CELL_SLOTS(CELL_SLOTS)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fr_wr_en),
        .wr_idx   (fr_wr_idx),
        .wr_data  (fr_wr_data),
        .commit   (fr_commit),
        .rd_en    (rd_en),
        .room     (st_room),
        .rd_avail (rd_avail),
        .rd_data  (rd_data),
        .rd_sop   (rd_sop),
        .rd_eop   (rd_eop)
    );

    assign tx_cell_room = st_room;
endmodule

// File: tb/sim_utx_cell_rx.sv
module sim_utx_cell_rx;
    localparam int NCELL = 53;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_par = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_soc = 1'b0;
    logic       tx_cell_room;
    logic       par_chk_en = 1'b0;
    logic       par_err_clr = 1'b0;
    logic       par_err;
    logic       rd_en = 1'b0;
    logic       rd_avail;
    logic [7:0] rd_data;
    logic       rd_sop;
    logic       rd_eop;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    utx_cell_rx u0 (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_par(tx_par),
        .tx_en(tx_en), .tx_soc(tx_soc), .tx_cell_room(tx_cell_room),
        .par_chk_en(par_chk_en), .par_err_clr(par_err_clr), .par_err(par_err),
        .rd_en(rd_en), .rd_avail(rd_avail), .rd_data(rd_data),
        .rd_sop(rd_sop), .rd_eop(rd_eop)
    );

    // {data[7:0], par, chk_en, expected flag}
    localparam logic [10:0] VEC [8] = '{
        {8'h00, 1'b1, 1'b1, 1'b0},
        {8'h00, 1'b0, 1'b1, 1'b1},
        {8'h01, 1'b0, 1'b1, 1'b0},
        {8'h01, 1'b1, 1'b1, 1'b1},
        {8'hFF, 1'b1, 1'b1, 1'b0},
        {8'hFF, 1'b0, 1'b1, 1'b1},
        {8'h5A, 1'b1, 1'b1, 1'b0},
        {8'h5A, 1'b0, 1'b0, 1'b0}
    };

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 37 + i * 5 + 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic soc, input bit good);
        tx_data = b;
        tx_soc  = soc;
        tx_en   = 1'b1;
        tx_par  = good ? ~^b : ^b;
        @(negedge clk);
        tx_en  = 1'b0;
        tx_soc = 1'b0;
    endtask

    // Send n bytes of cell 'seed'; byte bad_i gets wrong parity; gaps insert idle clocks.
    task automatic send_cell(input int seed, input int n, input int bad_i, input bit gaps);
        for (int i = 0; i < n; i++) begin
            send_byte(pat(seed, i), i == 0, i != bad_i);
            if (gaps && (i % 3 == 1)) begin
                tx_data = 8'hC3;
                @(negedge clk);
            end
        end
    endtask

    task automatic read_cell(input int seed, input string tag);
        int bad = 0;
        int first_i = -1;
        int act = 0;
        for (int i = 0; i < NCELL; i++) begin
            if (!rd_avail || rd_data != pat(seed, i) ||
                rd_sop != (i == 0) || rd_eop != (i == NCELL - 1)) begin
                if (first_i < 0) begin
                    first_i = i;
                    act = int'(rd_data);
                end
                bad++;
            end
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        chk(bad == 0, tag, act, (first_i < 0) ? 0 : int'(pat(seed, first_i)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(tx_cell_room == 1'b1, "R10 room after reset", tx_cell_room, 1);
        chk(rd_avail == 1'b0, "R10 avail after reset", rd_avail, 0);
        chk(par_err == 1'b0, "R10 flag after reset", par_err, 0);

        // R5 parity table: clear flag, one byte outside any cell, check flag
        for (int k = 0; k < 8; k++) begin
            par_err_clr = 1'b1;
            @(negedge clk);
            par_err_clr = 1'b0;
            par_chk_en  = VEC[k][1];
            tx_data = VEC[k][10:3];
            tx_par  = VEC[k][2];
            tx_en   = 1'b1;
            @(negedge clk);
            tx_en = 1'b0;
            chk(par_err == VEC[k][0], "R5 parity vector", par_err, VEC[k][0]);
        end
        par_err_clr = 1'b1;
        @(negedge clk);
        par_err_clr = 1'b0;
        par_chk_en  = 1'b1;

        // R3 bytes before any start-of-cell are ignored
        for (int i = 0; i < 10; i++) send_byte(8'(i), 1'b0, 1'b1);
        chk(rd_avail == 1'b0, "R3 no cell from stray bytes", rd_avail, 0);

        // R2 plain cell, then one with idle gaps
        send_cell(1, NCELL, -1, 1'b0);
        chk(rd_avail == 1'b1, "R2 cell stored", rd_avail, 1);
        read_cell(1, "R2 readback");
        chk(rd_avail == 1'b0, "R9 empty after read", rd_avail, 0);
        send_cell(2, NCELL, -1, 1'b1);
        read_cell(2, "R2 readback with gaps");

        // R4 early start-of-cell discards the partial cell
        send_cell(3, 20, -1, 1'b0);
        chk(rd_avail == 1'b0, "R4 partial not stored", rd_avail, 0);
        send_cell(4, NCELL, -1, 1'b0);
        read_cell(4, "R4 restarted cell");
        chk(rd_avail == 1'b0, "R4 only one cell", rd_avail, 0);

        // R6/R7 bad byte inside a cell, with clear in the same cycle
        send_cell(5, 10, -1, 1'b0);
        par_err_clr = 1'b1;
        send_byte(pat(5, 10), 1'b0, 1'b0);
        par_err_clr = 1'b0;
        chk(par_err == 1'b1, "R7 set wins over clear", par_err, 1);
        for (int i = 11; i < NCELL; i++) send_byte(pat(5, i), 1'b0, 1'b1);
        chk(par_err == 1'b1, "R7 flag sticky", par_err, 1);
        read_cell(5, "R6 errored cell intact");
        par_err_clr = 1'b1;
        @(negedge clk);
        par_err_clr = 1'b0;
        chk(par_err == 1'b0, "R7 clear pulse", par_err, 0);

        // R1/R8 fill both slots, push a cell while full, drain
        send_cell(6, NCELL, -1, 1'b0);
        chk(tx_cell_room == 1'b1, "R1 room with one cell", tx_cell_room, 1);
        send_cell(7, NCELL, -1, 1'b0);
        chk(tx_cell_room == 1'b0, "R1 no room when full", tx_cell_room, 0);
        send_cell(8, NCELL, -1, 1'b0);
        read_cell(6, "R8 first stored cell");
        chk(tx_cell_room == 1'b1, "R1 room back after read", tx_cell_room, 1);
        read_cell(7, "R8 second stored cell");
        chk(rd_avail == 1'b0, "R8 dropped cell absent", rd_avail, 0);

        // R9 read strobe while empty is ignored
        rd_en = 1'b1;
        repeat (5) @(negedge clk);
        rd_en = 1'b0;
        send_cell(9, NCELL, -1, 1'b0);
        chk(rd_sop == 1'b1, "R9 start marker after idle reads", rd_sop, 1);
        read_cell(9, "R9 readback after idle reads");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule